// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the slave-side protocol engine of a byte-wide serial memory on a two-wire bus. It samples SCL and SDA in a fast system clock domain and finds start and stop conditions. It checks the device address byte and loads a two-byte word address. It then performs byte writes, page writes, and current-address, random and sequential reads against an internal array of `2**ADDR_W` bytes. The block drives SDA only through an open-drain enable (`sda_pull_low`), so it either pulls the line low or leaves it released.

A self-timed programming interval follows every completed write. It is modelled by a counter of `WR_CYCLES` system clocks. During that interval the device address is not acknowledged, so a master can poll until the device answers again. A single address pointer serves writes and reads. On writes it wraps inside a 64-byte page. On reads it wraps across the whole array.

The controller has eight states. `S_IDLE` waits for a start. `S_DEV` shifts in the device address byte: on a match it goes to `S_ACK`, and on a mismatch or while busy it returns to `S_IDLE`. `S_AHI` and `S_ALO` shift in the high and low word-address bytes, and `S_WDAT` shifts in data bytes. Each of these goes to `S_ACK` after its eighth bit. `S_ACK` holds SDA low for the ninth clock and then moves on to the state recorded at entry: `S_AHI`, `S_ALO`, `S_WDAT` or `S_RDAT`. `S_RDAT` shifts a byte out and then goes to `S_MACK`. `S_MACK` samples the master's acknowledge. An acknowledge leads back to `S_RDAT` with the next byte, and a missing acknowledge leads to `S_IDLE`. A start from any state leads to `S_DEV`, and a stop from any state leads to `S_IDLE`.

Top module: `twi_mem_slave`

## Requirements
- R1: The device address byte is acknowledged only when bits 7..4 equal 1010 and bits 3..1 equal `strap_addr`. Bit 0 selects the operation: 1 is a read and 0 is a write. Any other byte gets no acknowledge, and the block ignores the bus until the next start.
- R2: The block acknowledges every byte it receives (device address, word address, data) by pulling SDA low for the whole ninth SCL clock. It releases the line after the ninth clock falls.
- R3: A write sends a high and then a low word-address byte after the device address, giving a 15-bit word address. Bit 7 of the high byte, and all address bits at or above `ADDR_W`, are don't-care.
- R4: After the stop that ends a write holding at least one unprotected data byte, the device address is not acknowledged for `WR_CYCLES` clocks. After that it is acknowledged again.
- R5: Each data byte of a write stores to the pointer. Afterwards only the low 6 bits of the pointer increment, so bytes past the end of a 64-byte page overwrite the start of the same page.
- R6: The pointer holds the last accessed address plus one. A read with no address phase (current-address read) returns the byte at the pointer. Reads advance the pointer across the full array and wrap from the last byte to address 0.
- R7: A read keeps returning successive bytes while the master acknowledges each one. After a missing acknowledge and a stop, the next current-address read continues at the following address.
- R8: While `wp` is high, data bytes of a write do not change the array, and the stop that ends the write starts no programming interval.
- R9: `sda_pull_low` is low after reset and changes only while SCL is low. A falling SDA while SCL is high is a start, and a rising SDA while SCL is high is a stop.
- R10: A start in the middle of a transfer abandons it and restarts device address decoding. This makes the dummy-write-then-read sequence of a random read work.
- R11: A write that ends with a start instead of a stop starts no programming interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired-AND of all drivers) |
| strap_addr | input | 3 | Board-strapped device select bits compared with address bits 3..1 |
| wp | input | 1 | Write protect; high blocks array updates |
| sda_pull_low | output | 1 | Open-drain enable: 1 pulls SDA low, 0 releases it |

## Verification
Every decision is taken about three system clocks after the SCL edge that causes it: two synchroniser flops plus the edge register. An acknowledge or output bit therefore appears a few clocks after an SCL fall. The bench holds each SCL phase for six clocks and samples SDA only at the middle of the next SCL high phase, well after that latency has passed. The programming interval is measured in whole polls. One poll is started at once after the write's stop and must be refused, since it ends before `WR_CYCLES` can expire. Polling then repeats until an acknowledge arrives, within a fixed bound.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_DEV, S_AHI, S_ALO, S_WDAT, S_ACK, S_RDAT, S_MACK
    } twi_state_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [2:0] scl_q;
    logic [2:0] sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 3'b111;
            sda_q <= 3'b111;
        end else begin
            scl_q <= {scl_q[1:0], scl_in};
            sda_q <= {sda_q[1:0], sda_in};
        end
    end

    // bit 1 is the settled value, bit 2 the value one clock earlier
    assign scl_s     = scl_q[1];
    assign sda_s     = sda_q[1];
    assign scl_rise  = scl_q[1] & ~scl_q[2];
    assign scl_fall  = ~scl_q[1] & scl_q[2];
    assign start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
    assign stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/twi_wr_timer.sv
module twi_wr_timer #(
    parameter int WR_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            left <= '0;
        else if (kick)         left <= CW'(WR_CYCLES);
        else if (left != '0)   left <= left - CW'(1);
    end

    assign busy = (left != '0);

    AST_TIMER_ARMS:  assert property (@(posedge clk) disable iff (!rst_n) kick |=> busy);               // R4
    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n) left <= CW'(WR_CYCLES));      // R4
endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
    import twi_mem_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int PAGE_W    = 6,
    parameter int WR_CYCLES = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] strap_addr,
    input  logic       wp,
    output logic       sda_pull_low
);
    localparam int HI_W = ADDR_W - 8;

    twi_state_t        state, nxt, ack_next;
    logic [3:0]        bit_cnt;
    logic [7:0]        shreg;
    logic [HI_W-1:0]   addr_hi;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] page_inc;
    logic [7:0]        arr_rdata;
    logic              wr_seen, m_acked;
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              busy, dev_hit, rx_state, byte_done, arr_we, wr_kick;

    twi_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twi_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .kick(wr_kick), .busy(busy)
    );

    twi_mem_array #(.AW(ADDR_W), .DW(8)) u_array (
        .clk(clk), .we(arr_we), .addr(addr), .wdata(shreg), .rdata(arr_rdata)
    );

    assign dev_hit   = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == strap_addr) && !busy;
    assign rx_state  = (state == S_DEV) || (state == S_AHI) || (state == S_ALO) || (state == S_WDAT);
    assign byte_done = rx_state && scl_fall && (bit_cnt == 4'd8);
    assign arr_we    = byte_done && (state == S_WDAT) && !wp;
    assign wr_kick   = stop_det && wr_seen;
    assign page_inc  = {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PAGE_W'(1)};

    // next-state logic
    always_comb begin
        nxt = state;
        if (start_det)      nxt = S_DEV;
        else if (stop_det)  nxt = S_IDLE;
        else begin
            unique case (state)
                S_IDLE: nxt = S_IDLE;
                S_DEV, S_AHI, S_ALO, S_WDAT:
                    if (byte_done) nxt = (state == S_DEV && !dev_hit) ? S_IDLE : S_ACK;
                S_ACK:  if (scl_fall) nxt = ack_next;
                S_RDAT: if (scl_fall && bit_cnt == 4'd8) nxt = S_MACK;
                S_MACK: if (scl_fall) nxt = m_acked ? S_RDAT : S_IDLE;
                default: nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // datapath and bus output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt      <= '0;
            shreg        <= '0;
            addr_hi      <= '0;
            addr         <= '0;
            ack_next     <= S_IDLE;
            wr_seen      <= 1'b0;
            m_acked      <= 1'b0;
            sda_pull_low <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt      <= '0;
            wr_seen      <= 1'b0;
            sda_pull_low <= 1'b0;
        end else begin
            case (state)
                S_DEV, S_AHI, S_ALO, S_WDAT: begin
                    if (scl_rise && bit_cnt < 4'd8) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done) begin
                        sda_pull_low <= (state != S_DEV) || dev_hit;
                        if (state == S_DEV) begin
                            ack_next <= shreg[0] ? S_RDAT : S_AHI;
                        end else if (state == S_AHI) begin
                            addr_hi  <= shreg[HI_W-1:0];
                            ack_next <= S_ALO;
                        end else if (state == S_ALO) begin
                            addr     <= {addr_hi, shreg};
                            ack_next <= S_WDAT;
                        end else begin
                            addr     <= page_inc;
                            ack_next <= S_WDAT;
                            if (!wp) wr_seen <= 1'b1;
                        end
                    end
                end
                S_ACK: if (scl_fall) begin
                    bit_cnt <= '0;
                    if (ack_next == S_RDAT) begin
                        shreg        <= arr_rdata;
                        sda_pull_low <= ~arr_rdata[7];
                        addr         <= addr + ADDR_W'(1);
                    end else begin
                        sda_pull_low <= 1'b0;
                    end
                end
                S_RDAT: begin
                    if (scl_rise && bit_cnt < 4'd8) bit_cnt <= bit_cnt + 4'd1;
                    if (scl_fall) begin
                        if (bit_cnt == 4'd8) begin
                            sda_pull_low <= 1'b0;
                        end else begin
                            shreg        <= {shreg[6:0], 1'b0};
                            sda_pull_low <= ~shreg[6];
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) m_acked <= ~sda_s;
                    if (scl_fall && m_acked) begin
                        bit_cnt      <= '0;
                        shreg        <= arr_rdata;
                        sda_pull_low <= ~arr_rdata[7];
                        addr         <= addr + ADDR_W'(1);
                    end
                end
                default: sda_pull_low <= 1'b0;
            endcase
        end
    end

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_pull_low) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);                  // R9
    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DEV && scl_fall && bit_cnt == 4'd8 && busy) |=> !sda_pull_low);                      // R4
    AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |=> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));                              // R5
    AST_BIT_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) bit_cnt <= 4'd8);        // R2
endmodule

// File: tb/test_twi_mem_slave.sv
module test_twi_mem_slave;
    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;
    localparam int PG    = 64;
    localparam int WRC   = 600;
    localparam int Q     = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
    logic [2:0] strap = 3'b101;
    logic sda_pull;
    logic sda_line;
    assign sda_line = sda_m & ~sda_pull;

    always #4 clk = ~clk;

    twi_mem_slave #(.ADDR_W(AW), .PAGE_W(6), .WR_CYCLES(WRC)) i_twi_mem_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .strap_addr(strap), .wp(wp), .sda_pull_low(sda_pull)
    );

    int n_chk = 0, n_bad = 0, bad_edges = 0, ref_ptr = 0;
    logic [7:0] ref_mem [DEPTH];
    bit         known   [DEPTH];
    logic       prev_pull = 1'b0;

    // R9 monitor: open-drain enable must not move while SCL is high
    always @(negedge clk) begin
        if (rst_n && sda_pull !== prev_pull && scl_m) bad_edges++;
        prev_pull = sda_pull;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dev(input bit rd);
        return {4'b1010, strap, rd};
    endfunction

    function automatic int page_next(input int p);
        return (p & ~(PG - 1)) | ((p + 1) & (PG - 1));
    endfunction

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b0; wq(1); scl_m = 1'b0; wq(1);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b1; wq(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ackd);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
        end
        sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1);
        ackd = (sda_line == 1'b0);
        wq(1); scl_m = 1'b0; wq(1);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(1); scl_m = 1'b1; wq(1); b[i] = sda_line; wq(1); scl_m = 1'b0;
        end
        wq(1);
        sda_m = give_ack ? 1'b0 : 1'b1; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
        sda_m = 1'b1;
    endtask

    task automatic wr_seq(input int a, input int n, input bit do_stop);
        logic ak;
        logic [7:0] d;
        int p;
        bus_start;
        send_byte(dev(1'b0), ak); chk("R1 write address ack", ak, 1);
        send_byte(a[15:8], ak);   chk("R3 high address ack", ak, 1);
        send_byte(a[7:0], ak);    chk("R3 low address ack", ak, 1);
        p = a & (DEPTH - 1);
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            send_byte(d, ak); chk("R2 data ack", ak, 1);
            if (!wp && do_stop) begin ref_mem[p] = d; known[p] = 1'b1; end
            p = page_next(p);
        end
        ref_ptr = p;
        if (do_stop) bus_stop;
    endtask

    task automatic wait_ready(output int polls);
        logic ak;
        polls = 0; ak = 1'b0;
        while (!ak && polls < 60) begin
            bus_start; send_byte(dev(1'b0), ak); bus_stop;
            if (!ak) polls++;
        end
        chk("R4 device answers after write interval", int'(ak), 1);
    endtask

    task automatic rd_seq(input int a, input int n, input string req);
        logic ak;
        logic [7:0] b;
        if (a >= 0) begin
            bus_start;
            send_byte(dev(1'b0), ak); chk("R10 dummy write ack", ak, 1);
            send_byte(a[15:8], ak);   chk("R3 high address ack", ak, 1);
            send_byte(a[7:0], ak);    chk("R3 low address ack", ak, 1);
            ref_ptr = a & (DEPTH - 1);
        end
        bus_start;
        send_byte(dev(1'b1), ak); chk("R1 read address ack", ak, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            if (known[ref_ptr]) chk(req, int'(b), int'(ref_mem[ref_ptr]));
            ref_ptr = (ref_ptr + 1) % DEPTH;
        end
        bus_stop;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic ak;
        int polls, a, n, len;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 released after reset", int'(sda_pull), 0);

        // R1: wrong type nibble, wrong strap
        bus_start; send_byte({4'b1011, strap, 1'b0}, ak); chk("R1 wrong type nibble", ak, 0); bus_stop;
        bus_start; send_byte({4'b1010, ~strap, 1'b0}, ak); chk("R1 wrong strap", ak, 0); bus_stop;

        // R4: byte write, immediate poll refused, then ready
        wr_seq(16'h0123, 1, 1'b1);
        bus_start; send_byte(dev(1'b0), ak); chk("R4 refused while busy", ak, 0); bus_stop;
        wait_ready(polls);
        chk("R4 at least one further refused poll", int'(polls >= 1), 1);
        rd_seq(16'h0123, 1, "R10 random read");

        // R6: current address read
        wr_seq(16'h0200, 2, 1'b1); wait_ready(polls);
        rd_seq(16'h0200, 1, "R6 random read first");
        rd_seq(-1, 1, "R6 current address read");

        // R3: don't-care upper bits
        wr_seq(16'hF9C4, 1, 1'b1); wait_ready(polls);
        rd_seq(16'h01C4, 1, "R3 upper address bits ignored");

        // R5: page wrap on write
        wr_seq(16'h033C, 66, 1'b1); wait_ready(polls);
        rd_seq(16'h0300, 64, "R5 page wrap");

        // R6: full-array wrap on read
        wr_seq(DEPTH - 2, 2, 1'b1); wait_ready(polls);
        wr_seq(16'h0000, 2, 1'b1); wait_ready(polls);
        rd_seq(DEPTH - 2, 4, "R6 read wraps to zero");

        // R7: sequential read ended by master, then continue
        rd_seq(16'h0300, 2, "R7 sequential read");
        rd_seq(-1, 1, "R7 resumes after missing acknowledge");

        // R8: write protect
        wp = 1'b1;
        wr_seq(16'h0300, 1, 1'b1);
        bus_start; send_byte(dev(1'b0), ak); chk("R8 no write interval when protected", ak, 1); bus_stop;
        wp = 1'b0;
        rd_seq(16'h0300, 1, "R8 protected byte unchanged");

        // R11: write ended by repeated start
        wr_seq(16'h0500, 2, 1'b0);
        bus_start; send_byte(dev(1'b0), ak); chk("R11 aborted write leaves device ready", ak, 1); bus_stop;

        // random writes and reads
        for (int it = 0; it < 6; it++) begin
            a = int'($urandom % DEPTH);
            n = 1 + int'($urandom % 16);
            wr_seq(a, n, 1'b1); wait_ready(polls);
            len = (n < PG - (a % PG)) ? n : PG - (a % PG);
            rd_seq(a, len, "R5 random write/read");
        end

        chk("R9 no SDA change while SCL high", bad_edges, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule